// File: doc/BRIEF.md
# Gated Dual-Mode Timer/Counter

This block is a timer/counter for a microcontroller core. Software reaches it through a small register bus: two byte-wide count registers (low and high) and one control register. The count either advances once per core clock (timer use) or once per falling edge seen on an external count pin (counter use). No prescaler sits in front of the count.

Counting is allowed only while the run bit is set. An optional gate makes counting also depend on the level of an external gate pin, so software can measure how long a pulse stays high. A width bit selects between a full 16-bit count and a 13-bit count. The 13-bit count is built from the whole high byte placed above the five low bits of the low byte.

When the count wraps from all ones to zero, an overflow flag is set and drives an interrupt request. Software or an interrupt-acknowledge pulse clears the flag. Both external pins pass through two-flop synchronizers before use.

Top module: `tct_timer`

## Requirements
- R1: With the width bit (control bit 3) set, the count is the 16-bit value {high, low}, and a carry out of the low byte increments the high byte.
- R2: With the width bit clear, the count is the 13-bit value {high, low[4:0]}. Bits 7:5 of the low register keep their written value and do not affect counting.
- R3: An increment that wraps the selected count from all ones to zero sets the overflow flag (control bit 4), and irq_req follows the flag.
- R4: An increment happens only when run (control bit 0) is 1 and either gate enable (control bit 1) is 0 or the synchronized gate_pin is 1. Otherwise the count holds.
- R5: Setting the run bit leaves the count registers unchanged.
- R6: With the source bit (control bit 2) at 0, the count advances by one on every core clock while enabled.
- R7: With the source bit at 1, the count advances by one for each falling edge of count_pin, detected after a two-flop synchronizer, and by at most one per clock.
- R8: After reset, the low, high and control registers read 0 and irq_req is 0.
- R9: Writing 0 to control bit 4, or a one-cycle irq_ack pulse, clears the flag. Writing 1 to bit 4 does not change the flag. A wrap in the same cycle sets the flag regardless of any clear.
- R10: A bus write to the low or high register takes priority over an increment in the same cycle: the written value is stored and that increment is dropped.
- R11: Register map on bus_addr: 0 is the low byte, 1 is the high byte, 2 is control {3'b0, flag, width, source, gate enable, run}, and 3 reads as 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gate_pin | input | 1 | External gate level (asynchronous) |
| count_pin | input | 1 | External count events (asynchronous) |
| irq_ack | input | 1 | Interrupt acknowledge pulse; clears the flag |
| irq_req | output | 1 | Interrupt request, equal to the overflow flag |

## Verification
A wrong count state is visible on the bus as soon as the registers are read back. Each stimulus row preloads a value, runs for an exact number of clocks and then compares both bytes, so a missed or extra increment shows up in the very next read. Faults in the 13-bit packing show up as a changed low-byte upper field or a carry that arrives late. Faults in synchronizer depth or edge detection show up as a wrong event total after a burst of pin toggles. A flag fault appears on irq_req in the cycle after the wrap or the acknowledge.

// File: rtl/tct_pkg.sv
package tct_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int LOW13_W = 5;

    localparam logic [ADDR_W-1:0] A_LOW  = 2'd0;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTL  = 2'd2;

    localparam int FLAG_BIT = 4;

    typedef struct packed {
        logic wide;
        logic ext_sel;
        logic gate_en;
        logic run;
    } tct_ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } tct_cnt_t;

    typedef struct packed {
        tct_ctrl_t ctl;
        logic      flag;
    } tct_reg_t;

endpackage

// File: rtl/tct_sync.sv
module tct_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES >= 2) begin : g_multi
            always_comb begin
                chain_d = {chain_q[STAGES-2:0], d};
            end
        end else begin : g_single
            always_comb begin
                chain_d = d;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tct_event.sv
module tct_event #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_pin,
    input  logic count_pin,
    input  logic run,
    input  logic gate_en,
    input  logic ext_sel,
    output logic inc_req
);
    logic gate_s, pin_s;
    logic prev_d, prev_q;
    logic fall, enable;

    tct_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({gate_pin, count_pin}),
        .q    ({gate_s, pin_s})
    );

    always_comb begin
        prev_d  = pin_s;
        fall    = prev_q & ~pin_s;
        enable  = run & (~gate_en | gate_s);
        inc_req = enable & (ext_sel ? fall : 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R7
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tct_ctrl.sv
module tct_ctrl
    import tct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [4:0]        wdata,
    input  logic              ovf_set,
    input  logic              irq_ack,
    output tct_ctrl_t         ctl,
    output logic              flag,
    output logic              wr_lo,
    output logic              wr_hi
);
    tct_reg_t reg_d, reg_q;
    logic     wr_ctl;

    always_comb begin
        wr_lo  = bus_wr && (bus_addr == A_LOW);
        wr_hi  = bus_wr && (bus_addr == A_HIGH);
        wr_ctl = bus_wr && (bus_addr == A_CTL);
        reg_d  = reg_q;
        if (wr_ctl) begin
            reg_d.ctl = tct_ctrl_t'(wdata[3:0]);
            if (!wdata[FLAG_BIT]) reg_d.flag = 1'b0;
        end
        if (irq_ack) reg_d.flag = 1'b0;
        if (ovf_set) reg_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign ctl  = reg_q.ctl;
    assign flag = reg_q.flag;

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> flag);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ovf_set) |=> !flag);

endmodule

// File: rtl/tct_count.sv
module tct_count
    import tct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_req,
    input  logic              wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi,
    output logic              ovf_set
);
    localparam int CW13 = DATA_W + LOW13_W;
    localparam int CW16 = 2 * DATA_W;
    localparam logic [CW13-1:0] ONE13 = 1;
    localparam logic [CW16-1:0] ONE16 = 1;

    tct_cnt_t cnt_d, cnt_q;
    logic [CW13-1:0] c13;
    logic [CW16-1:0] c16;
    logic            wr_any, do_inc, full;

    always_comb begin
        cnt_d  = cnt_q;
        c13    = {cnt_q.hi, cnt_q.lo[LOW13_W-1:0]};
        c16    = {cnt_q.hi, cnt_q.lo};
        wr_any = wr_lo | wr_hi;
        do_inc = inc_req & ~wr_any;
        full   = wide ? (&c16) : (&c13);
        if (wr_any) begin
            if (wr_lo) cnt_d.lo = wdata;
            if (wr_hi) cnt_d.hi = wdata;
        end else if (inc_req) begin
            if (wide) {cnt_d.hi, cnt_d.lo} = c16 + ONE16;
            else      {cnt_d.hi, cnt_d.lo[LOW13_W-1:0]} = c13 + ONE13;
        end
        ovf_set = do_inc & full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign lo = cnt_q.lo;
    assign hi = cnt_q.hi;

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_req && !wr_lo && !wr_hi) |=> $stable(cnt_q));
    // R1
    step16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_req && wide && !wr_lo && !wr_hi)
        |=> {hi, lo} == $past({hi, lo}) + ONE16);
    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !wr_lo) |=> $stable(lo[DATA_W-1:LOW13_W]));
    // R3
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> (hi == '0) && (lo[LOW13_W-1:0] == '0));
    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> lo == $past(wdata));

endmodule

// File: rtl/tct_timer.sv
module tct_timer
    import tct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              gate_pin,
    input  logic              count_pin,
    input  logic              irq_ack,
    output logic              irq_req
);
    tct_ctrl_t         ctl;
    logic              flag, wr_lo, wr_hi, inc_req, ovf_set;
    logic [DATA_W-1:0] lo, hi;

    tct_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wdata   (bus_wdata[4:0]),
        .ovf_set (ovf_set),
        .irq_ack (irq_ack),
        .ctl     (ctl),
        .flag    (flag),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi)
    );

    tct_event #(.SYNC_STAGES(SYNC_STAGES)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_pin (gate_pin),
        .count_pin(count_pin),
        .run      (ctl.run),
        .gate_en  (ctl.gate_en),
        .ext_sel  (ctl.ext_sel),
        .inc_req  (inc_req)
    );

    tct_count u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_req(inc_req),
        .wide   (ctl.wide),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (bus_wdata),
        .lo     (lo),
        .hi     (hi),
        .ovf_set(ovf_set)
    );

    always_comb begin
        case (bus_addr)
            A_LOW:   bus_rdata = lo;
            A_HIGH:  bus_rdata = hi;
            A_CTL:   bus_rdata = {3'b000, flag, ctl};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_req = flag;

    // R3
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> irq_req);

endmodule

// File: tb/sim_tct_timer.sv
module sim_tct_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gate_pin = 1'b0;
    logic       count_pin = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq_req;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    tct_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_pin(gate_pin),
        .count_pin(count_pin), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // {wide, hi, lo, cycles[15:0], exp_hi, exp_lo, exp_flag}
    localparam logic [49:0] VECS [7] = '{
        {1'b1, 8'h00, 8'h00, 16'd10, 8'h00, 8'h0A, 1'b0},
        {1'b1, 8'hFF, 8'hFE, 16'd3,  8'h00, 8'h01, 1'b1},
        {1'b0, 8'hFF, 8'hFE, 16'd3,  8'h00, 8'hE1, 1'b1},
        {1'b0, 8'h12, 8'hA0, 16'd5,  8'h12, 8'hA5, 1'b0},
        {1'b1, 8'h00, 8'hFF, 16'd1,  8'h01, 8'h00, 1'b0},
        {1'b0, 8'h00, 8'h1F, 16'd1,  8'h01, 8'h00, 1'b0},
        {1'b0, 8'h12, 8'hE0, 16'd40, 8'h13, 8'hE8, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // preload, run for n increments in clock mode, stop (flag write-1 keeps flag)
    task automatic run_n(input logic [7:0] base, input int n);
        wr(2'd2, base | 8'h01);
        repeat (n - 1) @(negedge clk);
        wr(2'd2, base | 8'h10);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state, R11 map
        rd(2'd0, v); chk("R8 low", v, 8'h00);
        rd(2'd1, v); chk("R8 high", v, 8'h00);
        rd(2'd2, v); chk("R8 ctl", v, 8'h00);
        rd(2'd3, v); chk("R11 unused addr", v, 8'h00);
        chk("R8 irq", {7'b0, irq_req}, 8'h00);

        // table walk: R1 R2 R3 R5 R6
        for (int i = 0; i < 7; i++) begin
            logic [49:0] e;
            logic [7:0]  base;
            e = VECS[i];
            base = {4'b0, e[49], 3'b000};
            wr(2'd2, base);
            wr(2'd0, e[40:33]);
            wr(2'd1, e[48:41]);
            run_n(base, int'(e[32:17]));
            rd(2'd0, v); chk("R1/R2/R5/R6 low", v, e[8:1]);
            rd(2'd1, v); chk("R1/R2/R5/R6 high", v, e[16:9]);
            rd(2'd2, v); chk("R3 flag", {7'b0, v[4]}, {7'b0, e[0]});
            chk("R3 irq", {7'b0, irq_req}, {7'b0, e[0]});
        end

        // R9 clear by ack
        wr(2'd2, 8'h08); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        run_n(8'h08, 1);
        chk("R9 flag before ack", {7'b0, irq_req}, 8'h01);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R9 ack clears", {7'b0, irq_req}, 8'h00);
        wr(2'd2, 8'h18);
        rd(2'd2, v); chk("R9 write one no set", v, 8'h08);
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        run_n(8'h08, 1);
        chk("R9 flag again", {7'b0, irq_req}, 8'h01);
        wr(2'd2, 8'h08);
        rd(2'd2, v); chk("R9 write zero clears", v, 8'h08);

        // R4 gate low blocks counting
        wr(2'd2, 8'h0A); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        gate_pin = 1'b0;
        repeat (4) @(negedge clk);
        run_n(8'h0A, 20);
        rd(2'd0, v); chk("R4 gate low holds", v, 8'h00);
        gate_pin = 1'b1;
        repeat (4) @(negedge clk);
        run_n(8'h0A, 7);
        rd(2'd0, v); chk("R4 gate high counts", v, 8'h07);
        gate_pin = 1'b0;
        wr(2'd2, 8'h08); wr(2'd0, 8'h00);
        run_n(8'h08, 5);
        rd(2'd0, v); chk("R4 gate ignored when disabled", v, 8'h05);

        // R7 external falling edges
        wr(2'd2, 8'h0C); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        count_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h0D);
        for (int k = 0; k < 6; k++) begin
            count_pin = 1'b0; repeat (3) @(negedge clk);
            count_pin = 1'b1; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R7 edge total", v, 8'h06);
        count_pin = 1'b0;
        repeat (10) @(negedge clk);
        rd(2'd0, v); chk("R7 one per edge", v, 8'h07);
        wr(2'd2, 8'h1C);

        // R10 write beats increment
        wr(2'd2, 8'h08); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'h09);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h18);
        rd(2'd0, v); chk("R10 low", v, 8'h41);
        rd(2'd1, v); chk("R10 high", v, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule